// File: doc/BRIEF.md
# Serial Link Status Register Tracker

This block keeps the 16-bit status word of one serial point-to-point link port. It watches the physical-layer training state, the data-link state flags, the retrain request strobe from the link control logic, the bandwidth-change indications and the negotiated lane count and link speed. From these it builds a registered status word. Software reads that word through a simple register port, and it clears the one sticky bit by writing 1 to it.

The sticky bandwidth flag collects every event that changes link bandwidth: a retrain request, a completed retrain, an autonomous change, and a non-autonomous change started by the far end. The training flag covers two cases. The first is the window between a retrain request and the start of training. The second is the time the training state machine spends in Configuration or Recovery. The width field is shown only in the operational link states, and only for a legal lane count.

The training state input uses this 4-bit encoding: 0 Detect, 1 Polling, 2 Configuration, 3 L0, 4 L0s, 5 L1, 6 L2, 7 Recovery, 8 Hot Reset, 9 Disabled, 10 Loopback.

Top module: `link_status_tracker`

## Requirements
- R1: In the cycle after reset, with all inputs at 0, `reg_rdata` reads 16'h1000.
- R2: Bit 14 becomes 1 in the cycle after `retrain_wr` is high. It becomes 0 after a register write whose data bit 14 is 1. A write with data bit 14 at 0 leaves it unchanged.
- R3: Bit 14 is set when a retrain that started with `retrain_wr` leaves Configuration or Recovery (state codes 2 and 7), as long as `dl_down` was not high between the request and the exit. If `dl_down` was high in that window, the exit sets nothing.
- R4: Bit 14 is set in the cycle after `auto_bw_change` or `remote_bw_change` is high.
- R5: When a bit-14 set event and a software clear of bit 14 happen in the same cycle, bit 14 reads 1 afterwards.
- R6: Bit 13 follows `dl_active` when the parameter DLLA_CAP is 1, and reads 0 when DLLA_CAP is 0.
- R7: Bit 12 always reads the value of the parameter SLOT_CLK_CFG, which defaults to 1.
- R8: Bit 11 reads 1 while the training state is Configuration (2) or Recovery (7).
- R9: After `retrain_wr`, bit 11 reads 1 until the training state first enters Configuration or Recovery. After that entry, bit 11 follows the state alone.
- R10: Bit 10 and bit 15 read 0. Register writes have no effect on any bit other than bit 14.
- R11: Bits 9:4 show `lane_count` only while the state is L0, L0s or L1 (3, 4, 5) and `lane_count` is one of 1, 2, 4, 8 or 16 (limited to MAX_LANES). In every other case they read 0.
- R12: Bits 3:0 show `link_speed`.
- R13: `reg_rdata` is registered. Every field reflects inputs sampled at the previous rising clock edge, and it does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_state | input | 4 | Encoded training state |
| dl_active | input | 1 | Data-link control in active state |
| dl_down | input | 1 | Data-link control in down state |
| retrain_wr | input | 1 | One-cycle strobe: 1 written to retrain control |
| auto_bw_change | input | 1 | Hardware autonomous speed/width change |
| remote_bw_change | input | 1 | Non-autonomous change started by the far end |
| lane_count | input | 6 | Negotiated lane count |
| link_speed | input | 4 | Current link speed code |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 16 | Status register write data |
| reg_rdata | output | 16 | Registered status word |

## Verification
The assertions assume four things about the inputs. `retrain_wr` and the bandwidth-change indications are single-cycle pulses. `train_state` carries only the eleven defined codes. `dl_down` and `dl_active` are never high together. A software clear always comes from a register write and never from the other inputs. The stimulus drives every input once per cycle, away from the clock edge. It uses only the defined state codes, pulses each strobe for exactly one cycle, and drops `dl_active` whenever it raises `dl_down`. Sticky-bit collisions are created on purpose by putting a set pulse and a clear write in the same cycle.

// File: rtl/lst_pkg.sv
package lst_pkg;

  localparam int REG_W   = 16;
  localparam int STATE_W = 4;
  localparam int LANE_W  = 6;

  localparam int BIT_BW    = 14;
  localparam int BIT_ACT   = 13;
  localparam int BIT_CLK   = 12;
  localparam int BIT_TRN   = 11;
  localparam int WID_LO    = 4;
  localparam int WID_HI    = WID_LO + LANE_W - 1;

  typedef enum logic [STATE_W-1:0] {
    TS_DETECT   = 4'd0,
    TS_POLLING  = 4'd1,
    TS_CONFIG   = 4'd2,
    TS_L0       = 4'd3,
    TS_L0S      = 4'd4,
    TS_L1       = 4'd5,
    TS_L2       = 4'd6,
    TS_RECOVERY = 4'd7,
    TS_HOTRST   = 4'd8,
    TS_DISABLED = 4'd9,
    TS_LOOPBACK = 4'd10
  } train_state_e;

  typedef enum logic [1:0] {
    RT_IDLE  = 2'd0,
    RT_WAIT  = 2'd1,
    RT_TRAIN = 2'd2
  } rt_state_e;

  function automatic logic in_cfg_rec(input logic [STATE_W-1:0] s);
    return (s == TS_CONFIG) || (s == TS_RECOVERY);
  endfunction

  function automatic logic in_oper(input logic [STATE_W-1:0] s);
    return (s == TS_L0) || (s == TS_L0S) || (s == TS_L1);
  endfunction

endpackage

// File: rtl/lst_width_decode.sv
module lst_width_decode
  import lst_pkg::*;
#(
  parameter int MAX_LANES = 16
) (
  input  logic [STATE_W-1:0] state,
  input  logic [LANE_W-1:0]  lanes,
  output logic [LANE_W-1:0]  field
);
  localparam int NCODE = $clog2(MAX_LANES) + 1;

  logic [NCODE-1:0] hit;

  for (genvar g = 0; g < NCODE; g++) begin : g_code
    assign hit[g] = (lanes == LANE_W'(1 << g));
  end

  always_comb begin
    field = '0;
    if (in_oper(state) && (|hit)) field = lanes;
  end
endmodule

// File: rtl/lst_retrain_track.sv
module lst_retrain_track
  import lst_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] state,
  input  logic               dl_down,
  input  logic               retrain_wr,
  output logic               done_evt,
  output logic               train_flag_d
);
  rt_state_e rt_q, rt_d;
  logic      pend_q, pend_d;
  logic      cr;

  assign cr = in_cfg_rec(state);

  always_comb begin
    rt_d     = rt_q;
    done_evt = 1'b0;
    if (retrain_wr) begin
      rt_d = cr ? RT_TRAIN : RT_WAIT;
    end else if (dl_down) begin
      rt_d = RT_IDLE;
    end else begin
      case (rt_q)
        RT_WAIT:  if (cr) rt_d = RT_TRAIN;
        RT_TRAIN: if (!cr) begin
                    rt_d     = RT_IDLE;
                    done_evt = 1'b1;
                  end
        default:  rt_d = RT_IDLE;
      endcase
    end
  end

  always_comb begin
    if (cr)              pend_d = 1'b0;
    else if (retrain_wr) pend_d = 1'b1;
    else                 pend_d = pend_q;
  end

  assign train_flag_d = pend_d | cr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_q   <= RT_IDLE;
      pend_q <= 1'b0;
    end else begin
      rt_q   <= rt_d;
      pend_q <= pend_d;
    end
  end

  // R9: the pending request survives until training starts
  a_r9_pending_hold: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !cr) |=> pend_q);
  // R9: entering Configuration/Recovery drops the pending request
  a_r9_pending_drop: assert property (@(posedge clk) disable iff (rst)
    cr |=> !pend_q);
  // R3: a link-down aborts any tracked retrain
  a_r3_down_aborts: assert property (@(posedge clk) disable iff (rst)
    (dl_down && !retrain_wr) |=> (rt_q == RT_IDLE));
endmodule

// File: rtl/lst_bw_sticky.sv
module lst_bw_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_retrain,
  input  logic set_done,
  input  logic set_auto,
  input  logic set_remote,
  input  logic sw_clear,
  output logic sticky_d
);
  logic sticky_q;
  logic set_any;

  assign set_any = set_retrain | set_done | set_auto | set_remote;

  always_comb begin
    if (set_any)       sticky_d = 1'b1;
    else if (sw_clear) sticky_d = 1'b0;
    else               sticky_d = sticky_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sticky_q <= 1'b0;
    else     sticky_q <= sticky_d;
  end

  // R5: a set event wins over a same-cycle clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_any && sw_clear) |=> sticky_q);
  // R2: a clear with no set event empties the flag
  a_r2_clear_works: assert property (@(posedge clk) disable iff (rst)
    (sw_clear && !set_any) |=> !sticky_q);
  // R2: without events the flag holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!sw_clear && !set_any) |=> $stable(sticky_q));
endmodule

// File: rtl/link_status_tracker.sv
module link_status_tracker
  import lst_pkg::*;
#(
  parameter int MAX_LANES    = 16,
  parameter int SPEED_W      = 4,
  parameter bit DLLA_CAP     = 1'b1,
  parameter bit SLOT_CLK_CFG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] train_state,
  input  logic               dl_active,
  input  logic               dl_down,
  input  logic               retrain_wr,
  input  logic               auto_bw_change,
  input  logic               remote_bw_change,
  input  logic [LANE_W-1:0]  lane_count,
  input  logic [SPEED_W-1:0] link_speed,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata
);
  localparam logic [REG_W-1:0] RESET_WORD = REG_W'(SLOT_CLK_CFG) << BIT_CLK;

  logic              done_evt;
  logic              trn_d;
  logic              bw_d;
  logic              act_bit;
  logic [LANE_W-1:0] wid;
  logic [REG_W-1:0]  word;
  logic              unused_wdata;

  assign unused_wdata = ^{reg_wdata[REG_W-1:BIT_BW+1], reg_wdata[BIT_BW-1:0]};

  lst_retrain_track u_track (
    .clk          (clk),
    .rst          (rst),
    .state        (train_state),
    .dl_down      (dl_down),
    .retrain_wr   (retrain_wr),
    .done_evt     (done_evt),
    .train_flag_d (trn_d)
  );

  lst_bw_sticky u_bw (
    .clk         (clk),
    .rst         (rst),
    .set_retrain (retrain_wr),
    .set_done    (done_evt),
    .set_auto    (auto_bw_change),
    .set_remote  (remote_bw_change),
    .sw_clear    (reg_wr && reg_wdata[BIT_BW]),
    .sticky_d    (bw_d)
  );

  lst_width_decode #(.MAX_LANES(MAX_LANES)) u_wid (
    .state (train_state),
    .lanes (lane_count),
    .field (wid)
  );

  if (DLLA_CAP) begin : g_act
    assign act_bit = dl_active;
  end else begin : g_noact
    assign act_bit = 1'b0;
  end

  always_comb begin
    word                = '0;
    word[BIT_BW]        = bw_d;
    word[BIT_ACT]       = act_bit;
    word[BIT_CLK]       = SLOT_CLK_CFG;
    word[BIT_TRN]       = trn_d;
    word[WID_HI:WID_LO] = wid;
    word[SPEED_W-1:0]   = link_speed;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= RESET_WORD;
    else     reg_rdata <= word;
  end

  // R11: outside the operational states the width field is empty
  a_r11_width_idle: assert property (@(posedge clk) disable iff (rst)
    !in_oper(train_state) |=> (reg_rdata[WID_HI:WID_LO] == '0));
  // R8: Configuration/Recovery shows training
  a_r8_training: assert property (@(posedge clk) disable iff (rst)
    in_cfg_rec(train_state) |=> reg_rdata[BIT_TRN]);
  // R4: bandwidth events show in the sticky bit
  a_r4_bw_event: assert property (@(posedge clk) disable iff (rst)
    (auto_bw_change || remote_bw_change) |=> reg_rdata[BIT_BW]);
  // R6: active mirror follows the link-active input
  a_r6_active: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (reg_rdata[BIT_ACT] == (DLLA_CAP && $past(dl_active))));
endmodule

// File: tb/link_status_tracker_bench.sv
`timescale 1ns/1ps
module link_status_tracker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  train_state = '0;
  logic        dl_active = 0, dl_down = 0, retrain_wr = 0;
  logic        auto_bw_change = 0, remote_bw_change = 0;
  logic [5:0]  lane_count = '0;
  logic [3:0]  link_speed = '0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  link_status_tracker u_link_status_tracker (
    .clk(clk), .rst(rst), .train_state(train_state), .dl_active(dl_active),
    .dl_down(dl_down), .retrain_wr(retrain_wr), .auto_bw_change(auto_bw_change),
    .remote_bw_change(remote_bw_change), .lane_count(lane_count),
    .link_speed(link_speed), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // {state[4], lanes[6], speed[4], dl_active[1], expected[16]}
  localparam int NV = 11;
  localparam logic [30:0] VEC [NV] = '{
    {4'd3, 6'd4,  4'd2, 1'b1, 16'h3042},  // R11 L0 x4, R12, R6
    {4'd4, 6'd16, 4'd3, 1'b1, 16'h3103},  // R11 L0s x16
    {4'd5, 6'd1,  4'd1, 1'b0, 16'h1011},  // R11 L1 x1, R6 inactive
    {4'd3, 6'd3,  4'd1, 1'b1, 16'h3001},  // R11 illegal count
    {4'd2, 6'd8,  4'd1, 1'b0, 16'h1801},  // R8 Configuration
    {4'd7, 6'd2,  4'd2, 1'b1, 16'h3802},  // R8 Recovery
    {4'd0, 6'd8,  4'd0, 1'b0, 16'h1000},  // R11 Detect
    {4'd3, 6'd8,  4'd4, 1'b1, 16'h3084},  // R11 L0 x8
    {4'd3, 6'd0,  4'd1, 1'b1, 16'h3001},  // R11 zero count
    {4'd6, 6'd1,  4'd1, 1'b0, 16'h1001},  // R11 L2
    {4'd3, 6'd32, 4'd1, 1'b1, 16'h3001}   // R11 above maximum
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic base_l0();
    train_state = 4'd3; lane_count = 6'd4; link_speed = 4'd2; dl_active = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    chk("R1 reset word", reg_rdata, 16'h1000);

    for (int i = 0; i < NV; i++) begin
      train_state = VEC[i][30:27];
      lane_count  = VEC[i][26:21];
      link_speed  = VEC[i][20:17];
      dl_active   = VEC[i][16];
      step();
      chk("R6/R7/R8/R11/R12 vector", reg_rdata, VEC[i][15:0]);
    end

    // R13: registered output holds between edges
    base_l0(); step();
    train_state = 4'd2; link_speed = 4'd7;
    #1 chk("R13 no change before edge", reg_rdata, 16'h3042);
    base_l0(); step();

    // R2 / R9 / R3: retrain that completes
    retrain_wr = 1; step(); retrain_wr = 0;
    chk("R2 set on retrain write, R9 pending", reg_rdata, 16'h7842);
    step(); step();
    chk("R9 pending held before training", reg_rdata, 16'h7842);
    train_state = 4'd2; step();
    chk("R8 in Configuration", reg_rdata, 16'h7802);
    train_state = 4'd7; reg_wr = 1; reg_wdata = 16'h4000; step(); reg_wr = 0;
    chk("R2 software clear", reg_rdata, 16'h3802);
    train_state = 4'd3; step();
    chk("R3 completion sets, R9 training ends", reg_rdata, 16'h7042);
    reg_wr = 1; reg_wdata = 16'hBFFF; step(); reg_wr = 0;
    chk("R2/R10 write of 0 and other bits ignored", reg_rdata, 16'h7042);
    reg_wr = 1; reg_wdata = 16'h4000; step(); reg_wr = 0;
    chk("R2 clear again", reg_rdata, 16'h3042);

    // R3: retrain aborted by link down
    retrain_wr = 1; step(); retrain_wr = 0;
    reg_wr = 1; reg_wdata = 16'h4000; step(); reg_wr = 0;
    chk("R9 pending after clear", reg_rdata, 16'h3842);
    train_state = 4'd2; dl_active = 0; dl_down = 1; step(); dl_down = 0;
    chk("R8 during aborted retrain", reg_rdata, 16'h1802);
    base_l0(); step();
    chk("R3 no set after link down", reg_rdata, 16'h3042);

    // R4
    auto_bw_change = 1; step(); auto_bw_change = 0;
    chk("R4 autonomous change", reg_rdata, 16'h7042);
    reg_wr = 1; reg_wdata = 16'h4000; step(); reg_wr = 0;
    remote_bw_change = 1; step(); remote_bw_change = 0;
    chk("R4 remote change", reg_rdata, 16'h7042);
    reg_wr = 1; reg_wdata = 16'h4000; step(); reg_wr = 0;
    chk("R2 cleared after remote", reg_rdata, 16'h3042);

    // R5
    auto_bw_change = 1; reg_wr = 1; reg_wdata = 16'hFFFF; step();
    auto_bw_change = 0; reg_wr = 0;
    chk("R5 set wins over clear", reg_rdata, 16'h7042);
    reg_wr = 1; reg_wdata = 16'h4000; step(); reg_wr = 0;
    chk("R5 later clear", reg_rdata, 16'h3042);

    // R9: retrain requested while already in Recovery
    train_state = 4'd7; step();
    retrain_wr = 1; step(); retrain_wr = 0;
    chk("R2 set during ongoing recovery", reg_rdata, 16'h7802);
    base_l0(); step();
    chk("R3/R9 exit after in-training request", reg_rdata, 16'h7042);

    // R1: reset again restores the word
    rst = 1; step(); rst = 0;
    train_state = 4'd0; lane_count = 0; link_speed = 0; dl_active = 0;
    step();
    chk("R1 reset clears sticky", reg_rdata, 16'h1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule